// File: doc/BRIEF.md
# Micro-op Unlamination and Issue Packer

This block sits between a queue of decoded micro-op descriptors and the rename/issue stage. Each cycle it looks at up to four descriptors at the head of the queue. For each one it decides whether the micro-op keeps a single fused-domain issue slot or has to be unlaminated into two consecutive slots. It then packs the resulting slots, in program order, into a four-slot issue packet. The decision depends on the memory access type, indexed addressing, RIP-relative addressing combined with an immediate, the number of register operands (with flags counted as one), and whether the destination is read-modify-write. A static mode pin selects between the rules of a core with a two-input limit per fused uop and a core with a three-input limit.

The input is one valid/ready pair per lane. Lanes are offered in program order from lane 0, with valid contiguous from lane 0. A lane is consumed on a cycle where both its valid and its ready are high. Ready is always a prefix of the valid lanes, and ready may depend on valid, because a lane is accepted only if its slots fit. The output is a registered packet with a valid bit per slot and a single ready from downstream. While downstream holds ready low and the packet is valid, the packet stays unchanged and no input lane is accepted.

When an unlaminated micro-op reaches the last free slot, only its first half issues. The second half leads the next packet. Three counters record fused-domain slots, unfused-domain uops and unlaminations, all taken from packets that are actually handed downstream.

Top module: `uop_issue_splitter`

## Requirements
- R1: A descriptor with no memory access, or a memory access without indexed addressing (load or store), uses one slot. Slot kind codes are 0 = plain, 1 = fused memory, 2 = split head, 3 = split tail. A non-memory slot has kind 0, and a non-indexed memory slot has kind 1.
- R2: With `mode_three_in` low, every indexed load or store descriptor splits into a head slot (kind 2) followed by a tail slot (kind 3) carrying the same tag.
- R3: With `mode_three_in` high, an indexed load stays fused (kind 1) only when `in_nops` (the register operand count, flags included, address registers excluded) equals 2 and `in_rmw` is set. Otherwise it splits, which covers flag readers, write-only destinations and three-operand forms.
- R4: With `mode_three_in` high, an indexed store stays fused (kind 1).
- R5: A memory descriptor with both `in_rip` and `in_imm` set takes one plain slot (kind 0), whatever its other flags. It adds one unfused uop and never counts as an unlamination.
- R6: Each issued packet holds at most four slots, filled contiguously from slot 0 in program order. Packing is greedy: a packet is filled to four slots whenever enough accepted input is available.
- R7: A split whose head lands in the last slot carries its tail, with the same tag, into slot 0 of the next packet.
- R8: Input lane l is consumed only when `in_valid[l]` and `in_ready[l]` are both high. `in_ready` is a prefix of `in_valid`. `in_ready` is zero while a valid packet is stalled.
- R9: While `out_ready` is low, a valid output packet (valid bits, kinds and tags) stays unchanged.
- R10: On each issued packet, `cnt_fused` adds one per valid slot. `cnt_unfused` adds two per kind-1 slot and one per other slot. `cnt_unlam` adds one per kind-2 slot.
- R11: After reset no output slot is valid and all counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_three_in | input | 1 | 1 = three-input-limit rules, 0 = two-input-limit rules; held steady while uops are in flight |
| in_valid | input | LANES | Per-lane descriptor valid, contiguous from lane 0 |
| in_ready | output | LANES | Per-lane accept, prefix of in_valid |
| in_load | input | LANES | Descriptor reads memory |
| in_store | input | LANES | Descriptor writes memory |
| in_idx | input | LANES | Address uses base plus index |
| in_rip | input | LANES | Address is RIP-relative |
| in_imm | input | LANES | Descriptor carries an immediate |
| in_rmw | input | LANES | Destination is read-modify-write |
| in_nops | input | LANES*OPS_W | Register operand count, flags included |
| in_tag | input | LANES*TAG_W | Opaque descriptor tag |
| out_valid | output | SLOTS | Per-slot valid of the issue packet |
| out_kind | output | SLOTS*2 | Per-slot kind code (see R1) |
| out_tag | output | SLOTS*TAG_W | Per-slot tag |
| out_ready | input | 1 | Downstream accepts the packet; low means stall |
| cnt_fused | output | CNT_W | Issued fused-domain slots |
| cnt_unfused | output | CNT_W | Issued unfused-domain uops |
| cnt_unlam | output | CNT_W | Issued unlaminations |

## Verification
The assertions check the structural rules of the handshake and the packet on every cycle: ready forms a valid prefix and falls during a stall, a stalled packet holds still, valid slots are contiguous, every head is followed by its tail in the same or the next packet, and the fused counter moves on each issue. Whether a given combination of flags and mode yields a fused slot, a split or a plain slot can only be shown by the bench's sweep, which compares the issued slot stream and the final counter totals with values derived from the rules. The same holds for greedy filling across a split that crosses a packet boundary.

// File: rtl/uop_issue_pkg.sv
package uop_issue_pkg;

  typedef enum logic [1:0] {
    SLOT_PLAIN = 2'd0,
    SLOT_FUSED = 2'd1,
    SLOT_HEAD  = 2'd2,
    SLOT_TAIL  = 2'd3
  } slot_kind_e;

  typedef enum logic [1:0] {
    CLS_PLAIN = 2'd0,
    CLS_FUSED = 2'd1,
    CLS_SPLIT = 2'd2
  } uop_class_e;

  function automatic int unsigned unfused_weight(input slot_kind_e k);
    return (k == SLOT_FUSED) ? 2 : 1;
  endfunction

endpackage

// File: rtl/uop_fuse_classify.sv
module uop_fuse_classify
  import uop_issue_pkg::*;
#(
  parameter int OPS_W = 2
) (
  input  logic             three_in_mode,
  input  logic             is_load,
  input  logic             is_store,
  input  logic             indexed,
  input  logic             rip_rel,
  input  logic             has_imm,
  input  logic             dst_rmw,
  input  logic [OPS_W-1:0] n_ops,
  output uop_class_e       cls
);

  localparam logic [OPS_W-1:0] TWO_OPS = OPS_W'(2);

  logic touches_mem;
  logic never_fused;
  logic keep_fused_wide;

  assign touches_mem     = is_load | is_store;
  assign never_fused     = rip_rel & has_imm;
  assign keep_fused_wide = is_store | ((n_ops == TWO_OPS) & dst_rmw);

  always_comb begin
    if (!touches_mem || never_fused) begin
      cls = CLS_PLAIN;
    end else if (!indexed) begin
      cls = CLS_FUSED;
    end else if (!three_in_mode) begin
      cls = CLS_SPLIT;
    end else if (keep_fused_wide) begin
      cls = CLS_FUSED;
    end else begin
      cls = CLS_SPLIT;
    end
  end

endmodule

// File: rtl/uop_slot_packer.sv
module uop_slot_packer
  import uop_issue_pkg::*;
#(
  parameter int LANES = 4,
  parameter int SLOTS = 4,
  parameter int TAG_W = 8
) (
  input  logic                   enable,
  input  logic                   carry_vld,
  input  logic [TAG_W-1:0]       carry_tag,
  input  logic [LANES-1:0]       lane_vld,
  input  uop_class_e             lane_cls [LANES],
  input  logic [LANES*TAG_W-1:0] lane_tag,
  output logic [LANES-1:0]       take,
  output logic [SLOTS-1:0]       slot_vld,
  output slot_kind_e             slot_kind [SLOTS],
  output logic [TAG_W-1:0]       slot_tag [SLOTS],
  output logic                   nxt_carry_vld,
  output logic [TAG_W-1:0]       nxt_carry_tag
);

  localparam int SIW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  int   used;
  logic open;
  logic [TAG_W-1:0] t;

  always_comb begin
    slot_vld      = '0;
    take          = '0;
    nxt_carry_vld = 1'b0;
    nxt_carry_tag = '0;
    t             = '0;
    for (int s = 0; s < SLOTS; s++) begin
      slot_kind[s] = SLOT_PLAIN;
      slot_tag[s]  = '0;
    end
    used = 0;
    open = enable;

    if (enable && carry_vld) begin
      slot_vld[0]  = 1'b1;
      slot_kind[0] = SLOT_TAIL;
      slot_tag[0]  = carry_tag;
      used         = 1;
    end

    for (int l = 0; l < LANES; l++) begin
      t = lane_tag[l*TAG_W +: TAG_W];
      if (open && lane_vld[l]) begin
        if (lane_cls[l] == CLS_SPLIT) begin
          if (used + 2 <= SLOTS) begin
            slot_vld[used[SIW-1:0]]        = 1'b1;
            slot_kind[used[SIW-1:0]]       = SLOT_HEAD;
            slot_tag[used[SIW-1:0]]        = t;
            slot_vld[(used + 1)]           = 1'b1;
            slot_kind[(used + 1)]          = SLOT_TAIL;
            slot_tag[(used + 1)]           = t;
            used                           = used + 2;
            take[l]                        = 1'b1;
          end else if (used < SLOTS) begin
            slot_vld[used[SIW-1:0]]  = 1'b1;
            slot_kind[used[SIW-1:0]] = SLOT_HEAD;
            slot_tag[used[SIW-1:0]]  = t;
            nxt_carry_vld            = 1'b1;
            nxt_carry_tag            = t;
            used                     = used + 1;
            take[l]                  = 1'b1;
          end else begin
            open = 1'b0;
          end
        end else if (used < SLOTS) begin
          slot_vld[used[SIW-1:0]]  = 1'b1;
          slot_kind[used[SIW-1:0]] = (lane_cls[l] == CLS_FUSED) ? SLOT_FUSED : SLOT_PLAIN;
          slot_tag[used[SIW-1:0]]  = t;
          used                     = used + 1;
          take[l]                  = 1'b1;
        end else begin
          open = 1'b0;
        end
      end else begin
        open = 1'b0;
      end
    end
  end

  always_comb begin
    assert (!(nxt_carry_vld && !slot_vld[SLOTS-1]))
      else $error("AST_CARRY_ONLY_WHEN_FULL"); // R7
  end

endmodule

// File: rtl/uop_issue_counters.sv
module uop_issue_counters
  import uop_issue_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [SLOTS-1:0] slot_vld,
  input  slot_kind_e       slot_kind [SLOTS],
  output logic [CNT_W-1:0] cnt_fused,
  output logic [CNT_W-1:0] cnt_unfused,
  output logic [CNT_W-1:0] cnt_unlam
);

  int unsigned add_f;
  int unsigned add_u;
  int unsigned add_l;

  always_comb begin
    add_f = 0;
    add_u = 0;
    add_l = 0;
    for (int s = 0; s < SLOTS; s++) begin
      if (slot_vld[s]) begin
        add_f = add_f + 1;
        add_u = add_u + unfused_weight(slot_kind[s]);
        if (slot_kind[s] == SLOT_HEAD) add_l = add_l + 1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_fused   <= '0;
      cnt_unfused <= '0;
      cnt_unlam   <= '0;
    end else if (fire) begin
      cnt_fused   <= cnt_fused + CNT_W'(add_f);
      cnt_unfused <= cnt_unfused + CNT_W'(add_u);
      cnt_unlam   <= cnt_unlam + CNT_W'(add_l);
    end
  end

  AST_FUSED_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && |slot_vld) |=> (cnt_fused != $past(cnt_fused))) else $error("AST_FUSED_MOVES"); // R10

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> ($stable(cnt_fused) && $stable(cnt_unfused) && $stable(cnt_unlam)))
    else $error("AST_IDLE_HOLDS"); // R10

endmodule

// File: rtl/uop_issue_splitter.sv
module uop_issue_splitter
  import uop_issue_pkg::*;
#(
  parameter int LANES = 4,
  parameter int SLOTS = 4,
  parameter int TAG_W = 8,
  parameter int OPS_W = 2,
  parameter int CNT_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mode_three_in,
  input  logic [LANES-1:0]       in_valid,
  output logic [LANES-1:0]       in_ready,
  input  logic [LANES-1:0]       in_load,
  input  logic [LANES-1:0]       in_store,
  input  logic [LANES-1:0]       in_idx,
  input  logic [LANES-1:0]       in_rip,
  input  logic [LANES-1:0]       in_imm,
  input  logic [LANES-1:0]       in_rmw,
  input  logic [LANES*OPS_W-1:0] in_nops,
  input  logic [LANES*TAG_W-1:0] in_tag,
  output logic [SLOTS-1:0]       out_valid,
  output logic [SLOTS*2-1:0]     out_kind,
  output logic [SLOTS*TAG_W-1:0] out_tag,
  input  logic                   out_ready,
  output logic [CNT_W-1:0]       cnt_fused,
  output logic [CNT_W-1:0]       cnt_unfused,
  output logic [CNT_W-1:0]       cnt_unlam
);

  uop_class_e       lane_cls [LANES];
  logic [LANES-1:0] take;
  logic [SLOTS-1:0] nxt_vld;
  slot_kind_e       nxt_kind [SLOTS];
  logic [TAG_W-1:0] nxt_tag  [SLOTS];
  logic             nxt_carry_vld;
  logic [TAG_W-1:0] nxt_carry_tag;

  logic [SLOTS-1:0] pkt_vld_q;
  slot_kind_e       pkt_kind_q [SLOTS];
  logic [TAG_W-1:0] pkt_tag_q  [SLOTS];
  logic             carry_vld_q;
  logic [TAG_W-1:0] carry_tag_q;

  logic advance;
  logic fire;

  assign fire    = out_ready & (|pkt_vld_q);
  assign advance = out_ready | ~(|pkt_vld_q);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    uop_fuse_classify #(.OPS_W(OPS_W)) u_cls (
      .three_in_mode (mode_three_in),
      .is_load       (in_load[l]),
      .is_store      (in_store[l]),
      .indexed       (in_idx[l]),
      .rip_rel       (in_rip[l]),
      .has_imm       (in_imm[l]),
      .dst_rmw       (in_rmw[l]),
      .n_ops         (in_nops[l*OPS_W +: OPS_W]),
      .cls           (lane_cls[l])
    );
  end

  uop_slot_packer #(.LANES(LANES), .SLOTS(SLOTS), .TAG_W(TAG_W)) u_pack (
    .enable        (advance),
    .carry_vld     (carry_vld_q),
    .carry_tag     (carry_tag_q),
    .lane_vld      (in_valid),
    .lane_cls      (lane_cls),
    .lane_tag      (in_tag),
    .take          (take),
    .slot_vld      (nxt_vld),
    .slot_kind     (nxt_kind),
    .slot_tag      (nxt_tag),
    .nxt_carry_vld (nxt_carry_vld),
    .nxt_carry_tag (nxt_carry_tag)
  );

  assign in_ready = take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_vld_q   <= '0;
      carry_vld_q <= 1'b0;
      carry_tag_q <= '0;
      for (int s = 0; s < SLOTS; s++) begin
        pkt_kind_q[s] <= SLOT_PLAIN;
        pkt_tag_q[s]  <= '0;
      end
    end else if (advance) begin
      pkt_vld_q   <= nxt_vld;
      carry_vld_q <= nxt_carry_vld;
      carry_tag_q <= nxt_carry_tag;
      for (int s = 0; s < SLOTS; s++) begin
        pkt_kind_q[s] <= nxt_kind[s];
        pkt_tag_q[s]  <= nxt_tag[s];
      end
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_out
    assign out_kind[s*2 +: 2]        = pkt_kind_q[s];
    assign out_tag[s*TAG_W +: TAG_W] = pkt_tag_q[s];
  end
  assign out_valid = pkt_vld_q;

  uop_issue_counters #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (fire),
    .slot_vld    (pkt_vld_q),
    .slot_kind   (pkt_kind_q),
    .cnt_fused   (cnt_fused),
    .cnt_unfused (cnt_unfused),
    .cnt_unlam   (cnt_unlam)
  );

  AST_READY_WITHIN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ((in_ready & ~in_valid) == '0) && (((in_ready + 1'b1) & in_ready) == '0))
    else $error("AST_READY_WITHIN_VALID"); // R8

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_ready && |out_valid) |-> (in_ready == '0))
    else $error("AST_STALL_BLOCKS_INPUT"); // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_ready && |out_valid) |=> ($stable(out_valid) && $stable(out_kind) && $stable(out_tag)))
    else $error("AST_STALL_HOLD"); // R9

  AST_SLOTS_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_valid + 1'b1) & out_valid) == '0)
    else $error("AST_SLOTS_CONTIG"); // R6

  AST_TAIL_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_valid[SLOTS-1] && out_kind[(SLOTS-1)*2 +: 2] == 2'(SLOT_HEAD))
      |=> (out_valid[0] && out_kind[1:0] == 2'(SLOT_TAIL)
           && out_tag[TAG_W-1:0] == $past(out_tag[(SLOTS-1)*TAG_W +: TAG_W])))
    else $error("AST_TAIL_LEADS"); // R7

  for (genvar s = 0; s < SLOTS - 1; s++) begin : g_pair
    AST_HEAD_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[s] && out_kind[s*2 +: 2] == 2'(SLOT_HEAD))
        |-> (out_valid[s+1] && out_kind[(s+1)*2 +: 2] == 2'(SLOT_TAIL)
             && out_tag[(s+1)*TAG_W +: TAG_W] == out_tag[s*TAG_W +: TAG_W]))
      else $error("AST_HEAD_PAIRED"); // R2
  end

endmodule

// File: tb/uop_issue_splitter_test.sv
module uop_issue_splitter_test;

  localparam int LANES = 4;
  localparam int SLOTS = 4;
  localparam int TW    = 8;
  localparam int OW    = 2;
  localparam int CW    = 32;
  localparam int MAXD  = 256;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                rst_n;
  logic                mode_three_in;
  logic [LANES-1:0]    in_valid, in_ready, in_load, in_store, in_idx, in_rip, in_imm, in_rmw;
  logic [LANES*OW-1:0] in_nops;
  logic [LANES*TW-1:0] in_tag;
  logic [SLOTS-1:0]    out_valid;
  logic [SLOTS*2-1:0]  out_kind;
  logic [SLOTS*TW-1:0] out_tag;
  logic                out_ready;
  logic [CW-1:0]       cnt_fused, cnt_unfused, cnt_unlam;

  uop_issue_splitter uut (
    .clk(clk), .rst_n(rst_n), .mode_three_in(mode_three_in),
    .in_valid(in_valid), .in_ready(in_ready), .in_load(in_load), .in_store(in_store),
    .in_idx(in_idx), .in_rip(in_rip), .in_imm(in_imm), .in_rmw(in_rmw),
    .in_nops(in_nops), .in_tag(in_tag), .out_valid(out_valid), .out_kind(out_kind),
    .out_tag(out_tag), .out_ready(out_ready), .cnt_fused(cnt_fused),
    .cnt_unfused(cnt_unfused), .cnt_unlam(cnt_unlam)
  );

  int n_cmp = 0;
  int n_bad = 0;

  logic       d_ld [MAXD], d_st [MAXD], d_ix [MAXD], d_rp [MAXD], d_im [MAXD], d_rw [MAXD];
  logic [1:0] d_no [MAXD];
  int         n_desc;

  logic [1:0] e_kind [2*MAXD];
  logic [7:0] e_tag  [2*MAXD];
  string      e_req  [2*MAXD];
  int         n_exp;
  int         ef, eu, el;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_run();
    n_desc = 0; n_exp = 0; ef = 0; eu = 0; el = 0;
  endtask

  // Expected behaviour from the requirements: 0 plain, 1 fused, 2 split
  task automatic add_desc(input bit mode, input bit ld, input bit st, input bit ix,
                          input bit rp, input bit im, input bit rw, input int nops);
    int    cls;
    string req;
    logic [7:0] tg;
    tg = 8'(n_desc);
    d_ld[n_desc] = ld; d_st[n_desc] = st; d_ix[n_desc] = ix;
    d_rp[n_desc] = rp; d_im[n_desc] = im; d_rw[n_desc] = rw; d_no[n_desc] = 2'(nops);
    n_desc++;
    if (!(ld || st))         begin cls = 0; req = "R1"; end
    else if (rp && im)       begin cls = 0; req = "R5"; end
    else if (!ix)            begin cls = 1; req = "R1"; end
    else if (!mode)          begin cls = 2; req = "R2"; end
    else if (st)             begin cls = 1; req = "R4"; end
    else if (nops == 2 && rw) begin cls = 1; req = "R3"; end
    else                     begin cls = 2; req = "R3"; end
    if (cls == 2) begin
      e_kind[n_exp] = 2'd2; e_tag[n_exp] = tg; e_req[n_exp] = req; n_exp++;
      e_kind[n_exp] = 2'd3; e_tag[n_exp] = tg; e_req[n_exp] = req; n_exp++;
      ef += 2; eu += 2; el += 1;
    end else begin
      e_kind[n_exp] = 2'(cls); e_tag[n_exp] = tg; e_req[n_exp] = req; n_exp++;
      ef += 1; eu += (cls == 1) ? 2 : 1;
    end
  endtask

  task automatic run(input bit mode, input bit stalls, input bit pos_check);
    int ptr, oi, cyc, pkt, acc;
    bit prev_stall;
    logic [SLOTS-1:0]    sv;
    logic [SLOTS*2-1:0]  sk;
    logic [SLOTS*TW-1:0] st;
    mode_three_in = mode;
    rst_n = 1'b0; in_valid = '0; out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_valid == '0, "R11 out_valid", int'(out_valid), 0);
    check(cnt_fused == '0 && cnt_unfused == '0 && cnt_unlam == '0, "R11 counters",
          int'(cnt_fused + cnt_unfused + cnt_unlam), 0);
    ptr = 0; oi = 0; cyc = 0; pkt = 0; prev_stall = 1'b0;
    sv = '0; sk = '0; st = '0;
    while ((ptr < n_desc || oi < n_exp) && cyc < 3000) begin
      @(negedge clk);
      for (int l = 0; l < LANES; l++) begin
        int k;
        k = ptr + l;
        in_valid[l] = (k < n_desc);
        if (k < n_desc) begin
          in_load[l] = d_ld[k]; in_store[l] = d_st[k]; in_idx[l] = d_ix[k];
          in_rip[l] = d_rp[k]; in_imm[l] = d_im[k]; in_rmw[l] = d_rw[k];
          in_nops[l*OW +: OW] = d_no[k]; in_tag[l*TW +: TW] = 8'(k);
        end else begin
          in_load[l] = 0; in_store[l] = 0; in_idx[l] = 0; in_rip[l] = 0;
          in_imm[l] = 0; in_rmw[l] = 0; in_nops[l*OW +: OW] = '0; in_tag[l*TW +: TW] = '0;
        end
      end
      out_ready = stalls ? (cyc % 5 != 2) : 1'b1;
      #5;
      if (prev_stall)
        check(out_valid == sv && out_kind == sk && out_tag == st, "R9 held packet",
              int'(out_valid), int'(sv));
      acc = 0;
      for (int l = 0; l < LANES; l++) if (in_valid[l] && in_ready[l] && acc == l) acc++;
      check((in_ready & ~in_valid) == '0 && $countones(in_ready) == acc, "R8 ready prefix",
            int'(in_ready), int'(in_valid));
      if (!out_ready && |out_valid) check(acc == 0, "R8 stall accepts", acc, 0);
      if (out_ready && |out_valid) begin
        pkt++;
        for (int s = 0; s < SLOTS; s++) begin
          if (out_valid[s]) begin
            if (oi < n_exp) begin
              check(out_kind[s*2 +: 2] == e_kind[oi], {e_req[oi], " slot kind"},
                    int'(out_kind[s*2 +: 2]), int'(e_kind[oi]));
              check(out_tag[s*TW +: TW] == e_tag[oi], {e_req[oi], " slot tag R6"},
                    int'(out_tag[s*TW +: TW]), int'(e_tag[oi]));
            end else begin
              check(1'b0, "R6 extra slot", oi, n_exp);
            end
            oi++;
          end
        end
        if (pos_check && pkt == 1) begin
          check(out_valid == 4'hF, "R6 greedy fill", int'(out_valid), 15);
          check(out_kind[7:6] == 2'd2 && out_tag[31:24] == 8'd3, "R7 head in last slot",
                int'(out_kind[7:6]), 2);
        end
        if (pos_check && pkt == 2)
          check(out_kind[1:0] == 2'd3 && out_tag[7:0] == 8'd3, "R7 tail leads packet",
                int'(out_kind[1:0]), 3);
      end
      prev_stall = !out_ready && |out_valid;
      sv = out_valid; sk = out_kind; st = out_tag;
      @(posedge clk);
      ptr += acc;
      cyc++;
    end
    check(cyc < 3000, "R6 stream completes", oi, n_exp);
    @(negedge clk);
    in_valid = '0;
    out_ready = 1'b0;
    #5;
    check(cnt_fused == CW'(ef), "R10 fused count", int'(cnt_fused), ef);
    check(cnt_unfused == CW'(eu), "R10 unfused count", int'(cnt_unfused), eu);
    check(cnt_unlam == CW'(el), "R10 unlamination count", int'(cnt_unlam), el);
  endtask

  task automatic build_sweep(input bit mode);
    clear_run();
    for (int m = 0; m < 3; m++)
      for (int ix = 0; ix < 2; ix++)
        for (int rp = 0; rp < 2; rp++)
          for (int im = 0; im < 2; im++)
            for (int rw = 0; rw < 2; rw++)
              for (int no = 0; no < 4; no++)
                add_desc(mode, m == 1, m == 2, ix[0], rp[0], im[0], rw[0], no);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_three_in = 1'b0; out_ready = 1'b0;
    in_valid = '0; in_load = '0; in_store = '0; in_idx = '0; in_rip = '0;
    in_imm = '0; in_rmw = '0; in_nops = '0; in_tag = '0;

    // R7 / R6: three plain then an indexed load in two-input mode
    clear_run();
    for (int i = 0; i < 8; i++) add_desc(1'b0, i == 3, 1'b0, i == 3, 1'b0, 1'b0, 1'b1, 2);
    run(1'b0, 1'b0, 1'b1);

    // R1 R2 R5: full sweep, two-input mode, with and without stalls
    build_sweep(1'b0);
    run(1'b0, 1'b0, 1'b0);
    build_sweep(1'b0);
    run(1'b0, 1'b1, 1'b0);

    // R1 R3 R4 R5: full sweep, three-input mode, with and without stalls
    build_sweep(1'b1);
    run(1'b1, 1'b0, 1'b0);
    build_sweep(1'b1);
    run(1'b1, 1'b1, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule